// File: doc/BRIEF.md
# Flash Burst Read Address Sequencer

This block produces the word address stream for a synchronous burst read out of a flash-style memory array. A host selects the device with an active-low chip select and pulses an active-low address strobe while presenting a start address. After a programmable number of clock edges, the block issues one word address per clock. Each address is marked with a data-valid flag. This continues until the host releases chip select or strobes a new address. The array is not part of the block. The testbench models it as a simple lookup that turns an address into a data word.

A small configuration register holds three settings: the burst ordering, the initial wait-state count, and the clock edge on which results are presented. The ordering is either a continuous count that rolls over at the top of the array, or a wrap inside an aligned block of 8, 16 or 32 words. A controller with three states sequences a burst:
- `ST_IDLE` has no burst active.
- `ST_WAIT` counts down the initial latency.
- `ST_STREAM` emits one address per clock.

Its transitions are:
- `start` (strobe seen while selected) goes from any state to `ST_WAIT`.
- `ready` (latency exhausted) goes from `ST_WAIT` to `ST_STREAM`.
- `deselect` (chip select high) goes from any state to `ST_IDLE`.
- `hold` keeps `ST_STREAM` stepping the address.

Top module: `flash_burst_seq`

## Requirements
- R1: After reset the configuration holds continuous ordering, a wait count of 7 and rising-edge presentation, so a burst issued without any configuration write shows its first word 7 edges after the strobe.
- R2: The ordering code `cfg_mode` is decoded as 2'b00 continuous, 2'b01 8-word wrap, 2'b10 16-word wrap and 2'b11 32-word wrap.
- R3: In continuous ordering each valid address is the previous one plus one, and the all-ones address is followed by address zero.
- R4: In an N-word wrap ordering, the low log2(N) address bits count up modulo N and the bits above them never change. Consequently the sequence returns to the start word after N words and never crosses a 64-word boundary.
- R5: When `addr_strobe_n` and `chip_sel_n` are both low at rising edge e, the first word (address equal to `start_addr`) becomes valid after rising edge e+W. W is the programmed wait count, and a programmed count of 0 behaves as 1.
- R6: `word_valid` is low out of reset, low during the latency and while idle, and high on every cycle of a burst.
- R7: A rising edge that samples `chip_sel_n` high ends any burst, and `word_valid` is low after that edge.
- R8: A new strobe during a burst or during its latency abandons it, reloads `start_addr` and restarts the latency count.
- R9: The ordering is captured at the strobe. A configuration write during a burst changes neither its ordering nor its latency and applies from the next burst.
- R10: With `cfg_fall` set to 1, outputs take the same values in the same order but change on the falling clock edge, half a period after the rising-edge presentation would.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write enable, sampled on the rising edge |
| cfg_mode | input | 2 | Burst ordering code to write |
| cfg_wait | input | WW (4) | Initial wait-state count to write |
| cfg_fall | input | 1 | 1 selects falling-edge presentation |
| chip_sel_n | input | 1 | Active-low chip select; high ends a burst |
| addr_strobe_n | input | 1 | Active-low start-address strobe |
| start_addr | input | AW (22) | Burst start word address |
| word_addr | output | AW (22) | Current burst word address |
| word_valid | output | 1 | High when `word_addr` carries a burst word |

## Verification
The hardest situation to reach from the ports is a change of configuration while a burst is still running, because the new ordering must stay dormant until the next strobe. The driver writes a new code during the latency of a wrapping burst. It then expects the wrap sequence to finish unchanged and the following burst to count continuously. Restarts are reached by strobing again on the exact cycle the last expected word appears. Edge selection is probed by sampling just after the rising edge on which the first word is due.

// File: rtl/flash_burst_seq_pkg.sv
package flash_burst_seq_pkg;

    typedef enum logic [1:0] {
        BM_LINEAR = 2'b00,
        BM_WRAP8  = 2'b01,
        BM_WRAP16 = 2'b10,
        BM_WRAP32 = 2'b11
    } burst_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_WAIT   = 2'b01,
        ST_STREAM = 2'b10
    } seq_state_e;

    localparam int unsigned NUM_MODES     = 4;
    localparam int unsigned WRAP_MIN_BITS = 3;

endpackage

// File: rtl/fbs_cfg_regs.sv
module fbs_cfg_regs
    import flash_burst_seq_pkg::*;
#(
    parameter int unsigned WW         = 4,
    parameter int unsigned RESET_WAIT = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [1:0]    mode_in,
    input  logic [WW-1:0] wait_in,
    input  logic          fall_in,
    output burst_mode_e   mode_q,
    output logic [WW-1:0] wait_q,
    output logic          fall_q
);

    localparam logic [WW-1:0] WAIT_RST = WW'(RESET_WAIT);

    // Power-on values: continuous ordering, typical latency, rising edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= BM_LINEAR;
            wait_q <= WAIT_RST;
            fall_q <= 1'b0;
        end else if (we) begin
            mode_q <= burst_mode_e'(mode_in);
            wait_q <= wait_in;
            fall_q <= fall_in;
        end
    end

endmodule

// File: rtl/fbs_addr_step.sv
module fbs_addr_step
    import flash_burst_seq_pkg::*;
#(
    parameter int unsigned AW = 22
) (
    input  logic [AW-1:0] addr,
    input  burst_mode_e   mode,
    output logic [AW-1:0] next_addr
);

    logic [AW-1:0] cand [NUM_MODES];

    // Code 0 counts through the whole array and rolls over at the top.
    assign cand[0] = addr + AW'(1);

    // Codes 1..3 increment only the low 3/4/5 bits, keeping the block fixed.
    for (genvar g = 1; g < NUM_MODES; g++) begin : g_wrap
        localparam int unsigned K = WRAP_MIN_BITS + g - 1;
        logic [K-1:0] low_inc;
        assign low_inc = addr[K-1:0] + K'(1);
        assign cand[g] = {addr[AW-1:K], low_inc};
    end

    assign next_addr = cand[mode];

endmodule

// File: rtl/fbs_seq_fsm.sv
module fbs_seq_fsm
    import flash_burst_seq_pkg::*;
#(
    parameter int unsigned AW = 22,
    parameter int unsigned WW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chip_sel_n,
    input  logic          addr_strobe_n,
    input  logic [AW-1:0] start_addr,
    input  burst_mode_e   cfg_mode,
    input  logic [WW-1:0] cfg_wait,
    output logic [AW-1:0] addr_q,
    output logic          valid_q,
    output burst_mode_e   mode_q
);

    seq_state_e    state_q, state_d;
    logic [WW-1:0] cnt_q;
    logic [WW-1:0] cnt_load;
    logic [AW-1:0] step_addr;
    logic          start_hit;

    assign start_hit = !chip_sel_n && !addr_strobe_n;
    // A programmed count of zero behaves as one edge of latency.
    assign cnt_load  = (cfg_wait == '0) ? '0 : cfg_wait - WW'(1);

    fbs_addr_step #(.AW(AW)) u_step (
        .addr      (addr_q),
        .mode      (mode_q),
        .next_addr (step_addr)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: deselect > start > ready/hold.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_hit) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (chip_sel_n)         state_d = ST_IDLE;
                else if (start_hit)     state_d = ST_WAIT;
                else if (cnt_q == '0)   state_d = ST_STREAM;
            end
            ST_STREAM: begin
                if (chip_sel_n)         state_d = ST_IDLE;
                else if (start_hit)     state_d = ST_WAIT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs and datapath.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            valid_q <= 1'b0;
            mode_q  <= BM_LINEAR;
            cnt_q   <= '0;
        end else begin
            valid_q <= (state_d == ST_STREAM);
            if (start_hit) begin
                addr_q <= start_addr;
                mode_q <= cfg_mode;
                cnt_q  <= cnt_load;
            end else begin
                if (state_q == ST_WAIT && cnt_q != '0)
                    cnt_q <= cnt_q - WW'(1);
                if (state_q == ST_STREAM && state_d == ST_STREAM)
                    addr_q <= step_addr;
            end
        end
    end

endmodule

// File: rtl/fbs_out_edge.sv
module fbs_out_edge #(
    parameter int unsigned AW = 22
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fall_sel,
    input  logic [AW-1:0] addr_in,
    input  logic          valid_in,
    output logic [AW-1:0] addr_out,
    output logic          valid_out
);

    logic [AW-1:0] addr_neg;
    logic          valid_neg;

    // Retiming stage clocked on the falling edge.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_neg  <= '0;
            valid_neg <= 1'b0;
        end else begin
            addr_neg  <= addr_in;
            valid_neg <= valid_in;
        end
    end

    assign addr_out  = fall_sel ? addr_neg  : addr_in;
    assign valid_out = fall_sel ? valid_neg : valid_in;

endmodule

// File: rtl/flash_burst_seq.sv
module flash_burst_seq
    import flash_burst_seq_pkg::*;
#(
    parameter int unsigned AW         = 22,
    parameter int unsigned WW         = 4,
    parameter int unsigned RESET_WAIT = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_mode,
    input  logic [WW-1:0] cfg_wait,
    input  logic          cfg_fall,
    input  logic          chip_sel_n,
    input  logic          addr_strobe_n,
    input  logic [AW-1:0] start_addr,
    output logic [AW-1:0] word_addr,
    output logic          word_valid
);

    burst_mode_e   mode_r;
    burst_mode_e   mode_snap;
    logic [WW-1:0] wait_r;
    logic          fall_r;
    logic [AW-1:0] seq_addr;
    logic          seq_valid;

    fbs_cfg_regs #(.WW(WW), .RESET_WAIT(RESET_WAIT)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .mode_in (cfg_mode),
        .wait_in (cfg_wait),
        .fall_in (cfg_fall),
        .mode_q  (mode_r),
        .wait_q  (wait_r),
        .fall_q  (fall_r)
    );

    fbs_seq_fsm #(.AW(AW), .WW(WW)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .chip_sel_n    (chip_sel_n),
        .addr_strobe_n (addr_strobe_n),
        .start_addr    (start_addr),
        .cfg_mode      (mode_r),
        .cfg_wait      (wait_r),
        .addr_q        (seq_addr),
        .valid_q       (seq_valid),
        .mode_q        (mode_snap)
    );

    fbs_out_edge #(.AW(AW)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall_sel  (fall_r),
        .addr_in   (seq_addr),
        .valid_in  (seq_valid),
        .addr_out  (word_addr),
        .valid_out (word_valid)
    );

endmodule

// File: rtl/flash_burst_seq_chk.sv
module flash_burst_seq_chk #(
    parameter int unsigned AW = 22
) (
    input logic          clk,
    input logic          rst_n,
    input logic          chip_sel_n,
    input logic          addr_strobe_n,
    input logic [AW-1:0] word_addr,
    input logic          word_valid,
    input logic [1:0]    burst_mode
);

    // R3: continuous ordering steps by one, rolling over at the top.
    a_r3_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && $past(word_valid) && burst_mode == 2'b00)
        |-> (word_addr == $past(word_addr) + AW'(1)));

    // R4: the lowest three bits always advance by one modulo 8.
    a_r4_low_step: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && $past(word_valid))
        |-> (word_addr[2:0] == $past(word_addr[2:0]) + 3'd1));

    // R4: wrapping orderings never leave the 64-word block.
    a_r4_block_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && $past(word_valid) && burst_mode != 2'b00)
        |-> (word_addr[AW-1:6] == $past(word_addr[AW-1:6])));

    // R5 / R8: the cycle after an accepted strobe is latency, never data.
    a_r5_strobe_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(addr_strobe_n) && !$past(chip_sel_n)) |-> !word_valid);

    // R7: a deselect sampled at an edge leaves no valid word behind it.
    a_r7_deselect_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $past(chip_sel_n) |-> !word_valid);

endmodule

bind flash_burst_seq flash_burst_seq_chk #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .chip_sel_n    (chip_sel_n),
    .addr_strobe_n (addr_strobe_n),
    .word_addr     (word_addr),
    .word_valid    (word_valid),
    .burst_mode    (u_fsm.mode_q)
);

// File: tb/flash_burst_seq_tb.sv
`timescale 1ns/1ps
module flash_burst_seq_tb;

    localparam int AW = 22;
    localparam int WW = 4;

    typedef struct {
        logic [AW-1:0] addr;
        int            cyc;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_mode = 2'b00;
    logic [WW-1:0] cfg_wait = '0;
    logic          cfg_fall = 1'b0;
    logic          chip_sel_n = 1'b1;
    logic          addr_strobe_n = 1'b1;
    logic [AW-1:0] start_addr = '0;
    logic [AW-1:0] word_addr;
    logic          word_valid;

    int   checks = 0;
    int   fails  = 0;
    int   cyc    = 0;
    bit   done   = 1'b0;
    exp_t sb[$];

    always #4 clk = ~clk;   // 125 MHz

    flash_burst_seq u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_mode      (cfg_mode),
        .cfg_wait      (cfg_wait),
        .cfg_fall      (cfg_fall),
        .chip_sel_n    (chip_sel_n),
        .addr_strobe_n (addr_strobe_n),
        .start_addr    (start_addr),
        .word_addr     (word_addr),
        .word_valid    (word_valid)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Stand-in array: address in, data word out.
    function automatic logic [15:0] array_word(input logic [AW-1:0] a);
        return a[15:0] ^ 16'hA5C3;
    endfunction

    // Expected successor, written from the ordering rules.
    function automatic logic [AW-1:0] succ(input logic [AW-1:0] a, input int m);
        logic [AW-1:0] sz;
        if (m == 0) return a + 1'b1;
        sz = AW'(4 << m);
        return (a & ~(sz - 1'b1)) | ((a + 1'b1) & (sz - 1'b1));
    endfunction

    task automatic check(input bit ok, input string tag, input logic [AW-1:0] act,
                         input logic [AW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pop the scoreboard whenever a word is presented.
    always @(negedge clk) begin
        #1;
        if (rst_n && word_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R6 unexpected valid word", word_addr, '0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(word_addr == e.addr && cyc == e.cyc &&
                      array_word(word_addr) == array_word(e.addr),
                      $sformatf("%s word (cycle %0d vs %0d)", e.tag, cyc, e.cyc),
                      word_addr, e.addr);
            end
        end
    end

    task automatic cfg_write(input int m, input int w, input bit f);
        @(posedge clk); #2;
        cfg_we = 1'b1; cfg_mode = 2'(m); cfg_wait = WW'(w); cfg_fall = f;
        @(posedge clk); #2;
        cfg_we = 1'b0;
    endtask

    // Driver: strobe a burst, push the expected words, then end or hand over.
    task automatic do_burst(input logic [AW-1:0] a0, input int m, input int w,
                            input bit fall, input int n, input bit end_ce,
                            input bit mid, input string tag);
        int weff;
        int e;
        logic [AW-1:0] a;
        weff = (w == 0) ? 1 : w;
        @(posedge clk); #2;
        chip_sel_n = 1'b0; addr_strobe_n = 1'b0; start_addr = a0;
        e = cyc + 1;
        a = a0;
        for (int i = 0; i < n; i++) begin
            sb.push_back('{a, e + weff + i, tag});
            a = succ(a, m);
        end
        @(posedge clk); #2;
        addr_strobe_n = 1'b1;
        if (mid) begin
            // R9: rewrite the configuration inside this burst's latency.
            cfg_we = 1'b1; cfg_mode = 2'b00; cfg_wait = WW'(3); cfg_fall = fall;
            fork
                begin @(posedge clk); #2; cfg_we = 1'b0; end
            join_none
        end
        repeat (weff - 1) @(posedge clk);
        @(posedge clk); #1;
        // R10: just after the first data edge, valid shows only for rising-edge mode.
        check(word_valid == !fall, $sformatf("R10 edge of first word (%s)", tag),
              AW'(word_valid), AW'(!fall));
        if (end_ce) begin
            repeat (n - 1) @(posedge clk);
            #1;
            chip_sel_n = 1'b1;
            @(posedge clk); #5;
            check(!word_valid, "R7 valid after deselect", AW'(word_valid), '0);
        end else begin
            repeat (n - 2) @(posedge clk);
        end
    endtask

    initial begin
        #(8 * 200000);
        check(1'b0, "watchdog expired", '0, '0);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        end
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk); #1;
        check(!word_valid, "R6 reset valid", AW'(word_valid), '0);

        // R1 / R5: defaults, no configuration write.
        do_burst(22'h000010, 0, 7, 1'b0, 4, 1'b1, 1'b0, "R1/R5");
        // R2 / R4: 8-word wrap.
        cfg_write(1, 3, 1'b0);
        do_burst(22'h000105, 1, 3, 1'b0, 10, 1'b1, 1'b0, "R2/R4 wrap8");
        // R2 / R4: 16-word wrap.
        cfg_write(2, 2, 1'b0);
        do_burst(22'h00002E, 2, 2, 1'b0, 18, 1'b1, 1'b0, "R2/R4 wrap16");
        // R4: 32-word wrap stays below the 64-word boundary.
        cfg_write(3, 4, 1'b0);
        do_burst(22'h00003D, 3, 4, 1'b0, 34, 1'b1, 1'b0, "R4 wrap32");
        // R3: continuous rollover at the top of the array.
        cfg_write(0, 1, 1'b0);
        do_burst(22'h3FFFFD, 0, 1, 1'b0, 6, 1'b1, 1'b0, "R3 rollover");
        // R5: zero wait behaves as one; maximum wait.
        cfg_write(0, 0, 1'b0);
        do_burst(22'h000077, 0, 0, 1'b0, 3, 1'b1, 1'b0, "R5 zero wait");
        cfg_write(0, 15, 1'b0);
        do_burst(22'h000200, 0, 15, 1'b0, 2, 1'b1, 1'b0, "R5 max wait");
        // R8: restart during a burst.
        cfg_write(1, 2, 1'b0);
        do_burst(22'h001006, 1, 2, 1'b0, 5, 1'b0, 1'b0, "R8 first");
        do_burst(22'h004000, 1, 2, 1'b0, 4, 1'b1, 1'b0, "R8 second");
        // R9: configuration written mid-burst applies only to the next one.
        cfg_write(1, 5, 1'b0);
        do_burst(22'h00000E, 1, 5, 1'b0, 12, 1'b1, 1'b1, "R9 old mode");
        do_burst(22'h00000E, 0, 3, 1'b0, 12, 1'b1, 1'b0, "R9 new mode");
        // R10: falling-edge presentation.
        cfg_write(2, 3, 1'b1);
        do_burst(22'h00005C, 2, 3, 1'b1, 20, 1'b1, 1'b0, "R10 wrap16");
        cfg_write(0, 4, 1'b1);
        do_burst(22'h3FFFFE, 0, 4, 1'b1, 4, 1'b1, 1'b0, "R10 rollover");

        repeat (6) @(posedge clk);
        #5;
        check(sb.size() == 0, "R6 words left unissued", AW'(sb.size()), '0);
        check(!word_valid, "R6 idle valid", AW'(word_valid), '0);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        end
        $finish;
    end

endmodule